// File: doc/BRIEF.md
# Sorted-Input Group-By Aggregator

This block reduces a stream of rows, each holding a group key and an unsigned data value, into one result row per group. The rows must arrive already ordered on the key. The block therefore finds group boundaries by comparing each key with the key of the row before it. It holds only the one group that is currently open: a running accumulator and a row counter. It never needs a table of groups.

One of five reductions applies to a whole stream: largest value, smallest value, row count, total, and integer mean. The mean is the floor of the total divided by the row count. It is computed by a serial divider, and the input is stalled while the divider runs. Values with a fractional part are expected as integers that were scaled before they reach the block.

Both sides use valid/ready handshakes. A beat moves when valid and ready are both high at a rising clock edge. Once out_valid is raised, the output row must stay unchanged until out_ready takes it. When the output slot holds a row that is not being drained, in_ready is low. The input side marks the end of a stream with in_last. A beat with in_hollow set carries no row and exists only to deliver that end marker.

Top module: `grp_agg_top`

## Requirements
- R1: After reset, out_valid is low and in_ready is high.
- R2: Consecutive accepted rows with equal keys are reduced into one group. A row whose key differs from the previous accepted row closes that group, and one result row is emitted carrying the old key.
- R3: The op_sel codes are 0 largest, 1 smallest, 2 row count, 3 total and 4 mean. Codes 5 to 7 act as total. All values are unsigned.
- R4: The total is kept in an accumulator CNT_W bits wider than the data. The output value is the low DATA_W bits of the exact total.
- R5: The mean is floor(exact total / row count) over the full-width total. While it is being divided, in_ready stays low for at least as many cycles as the accumulator has bits.
- R6: A row beat with in_last ends the stream. Its group is emitted with out_last high, even when that row opened a new group in the same beat. A hollow beat with in_last closes the open group as the last one. A hollow beat without in_last has no effect.
- R7: A stream that consists only of a hollow beat with in_last produces no output row.
- R8: op_sel is captured at the first row of a stream. Changes to it before the stream ends have no effect on that stream.
- R9: While out_valid is high and out_ready is low, out_key, out_value and out_last hold steady and in_ready is low. Every group is delivered exactly once, in input order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_sel | input | 3 | Reduction code, captured at the first row of a stream |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block accepts the input beat |
| in_key | input | KEY_W | Group key of the row |
| in_data | input | DATA_W | Value to reduce |
| in_last | input | 1 | Final beat of the stream |
| in_hollow | input | 1 | Beat carries no row, only a possible end marker |
| out_valid | output | 1 | Result row present |
| out_ready | input | 1 | Consumer takes the result row |
| out_key | output | KEY_W | Key of the finished group |
| out_value | output | DATA_W | Reduced value of the group |
| out_last | output | 1 | Result row is the final group of the stream |

## Verification
A wrong open-group state shows up as a bad value on the next result row. That row appears in the cycle after the key changes, or after the divider's run in mean mode, so a corruption surfaces within one group. A stale key comparison shows up as merged or split groups, which the bench sees as a wrong count of output rows. A faulty end-of-stream path shows up as a missing out_last, a missing final row, or a spurious row for an empty stream. Back-pressure mistakes show up as rows that change while stalled or that arrive twice. Stimulus is driven with and without output stalls.

// File: rtl/agg_pkg.sv
package agg_pkg;
  typedef enum logic [2:0] {
    OP_MAX = 3'd0,
    OP_MIN = 3'd1,
    OP_CNT = 3'd2,
    OP_SUM = 3'd3,
    OP_AVG = 3'd4
  } agg_op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ACC   = 2'd1,
    ST_DIV   = 2'd2,
    ST_FLUSH = 2'd3
  } agg_st_e;

  // unused codes fall back to the total
  function automatic agg_op_e norm_op(input logic [2:0] code);
    case (code)
      3'd0:    return OP_MAX;
      3'd1:    return OP_MIN;
      3'd2:    return OP_CNT;
      3'd4:    return OP_AVG;
      default: return OP_SUM;
    endcase
  endfunction
endpackage

// File: rtl/agg_fold.sv
module agg_fold
  import agg_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SUM_W  = 64
) (
  input  agg_op_e             op,
  input  logic                first,
  input  logic [SUM_W-1:0]    acc,
  input  logic [DATA_W-1:0]   data,
  output logic [SUM_W-1:0]    nxt
);
  logic [SUM_W-1:0] data_x;
  logic [DATA_W-1:0] acc_lo;

  always_comb begin
    data_x = SUM_W'(data);
    acc_lo = acc[DATA_W-1:0];
    if (first) begin
      nxt = data_x;
    end else begin
      case (op)
        OP_MAX:  nxt = (data > acc_lo) ? data_x : acc;
        OP_MIN:  nxt = (data < acc_lo) ? data_x : acc;
        OP_CNT:  nxt = acc;
        default: nxt = acc + data_x;
      endcase
    end
  end
endmodule

// File: rtl/agg_div.sv
module agg_div #(
  parameter int N_W = 64,
  parameter int D_W = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [N_W-1:0] dividend,
  input  logic [D_W-1:0] divisor,
  output logic           busy,
  output logic [N_W-1:0] quot
);
  localparam int IW = $clog2(N_W + 1);

  logic [D_W:0]   rem;
  logic [N_W-1:0] q;
  logic [D_W-1:0] dv;
  logic [IW-1:0]  steps;
  logic [D_W:0]   shifted;
  logic           fits;
  logic [D_W:0]   rem_n;

  always_comb begin
    shifted = {rem[D_W-1:0], q[N_W-1]};
    fits    = shifted >= {1'b0, dv};
    rem_n   = fits ? (shifted - {1'b0, dv}) : shifted;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem   <= '0;
      q     <= '0;
      dv    <= '0;
      steps <= '0;
      busy  <= 1'b0;
    end else if (start) begin
      rem   <= '0;
      q     <= dividend;
      dv    <= divisor;
      steps <= IW'(N_W);
      busy  <= 1'b1;
    end else if (busy) begin
      rem   <= rem_n;
      q     <= {q[N_W-2:0], fits};
      steps <= steps - 1'b1;
      if (steps == IW'(1)) busy <= 1'b0;
    end
  end

  assign quot = q;
endmodule

// File: rtl/grp_agg_top.sv
module grp_agg_top
  import agg_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int KEY_W  = 16,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [2:0]        op_sel,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [KEY_W-1:0]  in_key,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_last,
  input  logic              in_hollow,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [KEY_W-1:0]  out_key,
  output logic [DATA_W-1:0] out_value,
  output logic              out_last
);
  localparam int SUM_W = DATA_W + CNT_W;

  agg_st_e           st, ret_st, after_emit;
  agg_op_e           op_q, op_now;
  logic [KEY_W-1:0]  cur_key, pend_key;
  logic [SUM_W-1:0]  acc, acc_nxt, cnt_x;
  logic [CNT_W-1:0]  cnt;
  logic              pend_last;

  logic slot_free, fire, row, same_key, close, flush_go, emit_go, emit_last;
  logic is_avg, fold_first, div_start, div_busy, div_fin, direct_load;
  logic grp_open, avg_mode;
  logic [SUM_W-1:0]  quot;
  logic [DATA_W-1:0] res_val;

  always_comb begin
    slot_free   = !out_valid || out_ready;
    in_ready    = ((st == ST_IDLE) || (st == ST_ACC)) && slot_free;
    fire        = in_valid && in_ready;
    row         = fire && !in_hollow;
    op_now      = (st == ST_IDLE) ? norm_op(op_sel) : op_q;
    same_key    = (in_key == cur_key);
    close       = fire && (st == ST_ACC) && (in_hollow ? in_last : !same_key);
    flush_go    = (st == ST_FLUSH) && slot_free;
    emit_go     = close || flush_go;
    emit_last   = flush_go || in_hollow;
    is_avg      = (op_q == OP_AVG);
    fold_first  = !((st == ST_ACC) && same_key);
    div_start   = emit_go && is_avg;
    direct_load = emit_go && !is_avg;
    div_fin     = (st == ST_DIV) && !div_busy && slot_free;
    cnt_x       = SUM_W'(cnt);
    res_val     = (op_q == OP_CNT) ? cnt_x[DATA_W-1:0] : acc[DATA_W-1:0];
    if (flush_go || in_hollow) after_emit = ST_IDLE;
    else if (in_last)          after_emit = ST_FLUSH;
    else                       after_emit = ST_ACC;
    grp_open    = (st == ST_ACC);
    avg_mode    = is_avg;
  end

  agg_fold #(.DATA_W(DATA_W), .SUM_W(SUM_W)) u_fold (
    .op    (op_now),
    .first (fold_first),
    .acc   (acc),
    .data  (in_data),
    .nxt   (acc_nxt)
  );

  agg_div #(.N_W(SUM_W), .D_W(CNT_W)) u_div (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (div_start),
    .dividend (acc),
    .divisor  (cnt),
    .busy     (div_busy),
    .quot     (quot)
  );

  // group state machine
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      ret_st    <= ST_IDLE;
      op_q      <= OP_SUM;
      cur_key   <= '0;
      acc       <= '0;
      cnt       <= '0;
      pend_key  <= '0;
      pend_last <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (row) begin
            op_q    <= op_now;
            cur_key <= in_key;
            acc     <= acc_nxt;
            cnt     <= CNT_W'(1);
            st      <= in_last ? ST_FLUSH : ST_ACC;
          end
        end
        ST_ACC: begin
          if (emit_go) begin
            if (is_avg) begin
              st        <= ST_DIV;
              ret_st    <= after_emit;
              pend_key  <= cur_key;
              pend_last <= emit_last;
            end else begin
              st <= after_emit;
            end
            if (row) begin
              cur_key <= in_key;
              acc     <= acc_nxt;
              cnt     <= CNT_W'(1);
            end
          end else if (row) begin
            acc <= acc_nxt;
            cnt <= cnt + 1'b1;
            if (in_last) st <= ST_FLUSH;
          end
        end
        ST_FLUSH: begin
          if (flush_go) begin
            if (is_avg) begin
              st        <= ST_DIV;
              ret_st    <= ST_IDLE;
              pend_key  <= cur_key;
              pend_last <= 1'b1;
            end else begin
              st <= ST_IDLE;
            end
          end
        end
        default: begin
          if (div_fin) st <= ret_st;
        end
      endcase
    end
  end

  // single output slot
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_key   <= '0;
      out_value <= '0;
      out_last  <= 1'b0;
    end else if (direct_load) begin
      out_valid <= 1'b1;
      out_key   <= cur_key;
      out_value <= res_val;
      out_last  <= emit_last;
    end else if (div_fin) begin
      out_valid <= 1'b1;
      out_key   <= pend_key;
      out_value <= quot[DATA_W-1:0];
      out_last  <= pend_last;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/grp_agg_chk.sv
module grp_agg_chk #(
  parameter int DATA_W = 32,
  parameter int KEY_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              in_hollow,
  input logic              in_last,
  input logic [KEY_W-1:0]  in_key,
  input logic              out_valid,
  input logic              out_ready,
  input logic [KEY_W-1:0]  out_key,
  input logic [DATA_W-1:0] out_value,
  input logic              out_last,
  input logic              div_busy,
  input logic              grp_open,
  input logic              avg_mode,
  input logic [KEY_W-1:0]  cur_key
);
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_key) && $stable(out_value) && $stable(out_last)); // R9

  AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready); // R9

  AST_DIV_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    div_busy |-> !in_ready); // R5

  AST_KEY_CLOSE: assert property (@(posedge clk) disable iff (!rst_n)
    grp_open && in_valid && in_ready && !in_hollow && (in_key != cur_key) && !avg_mode
    |=> out_valid && (out_key == $past(cur_key)) && !out_last); // R2

  AST_EMPTY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !grp_open && !out_valid && in_valid && in_ready && in_hollow |=> !out_valid); // R7

  AST_HOLLOW_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    grp_open && in_valid && in_ready && in_hollow && in_last && !avg_mode
    |=> out_valid && out_last); // R6
endmodule

bind grp_agg_top grp_agg_chk #(.DATA_W(DATA_W), .KEY_W(KEY_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_hollow (in_hollow),
  .in_last   (in_last),
  .in_key    (in_key),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_key   (out_key),
  .out_value (out_value),
  .out_last  (out_last),
  .div_busy  (div_busy),
  .grp_open  (grp_open),
  .avg_mode  (avg_mode),
  .cur_key   (cur_key)
);

// File: tb/sim_grp_agg_top.sv
`timescale 1ns/1ps
module sim_grp_agg_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  op_sel = 3'd3;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_key = '0;
  logic [31:0] in_data = '0;
  logic        in_last = 1'b0;
  logic        in_hollow = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [15:0] out_key;
  logic [31:0] out_value;
  logic        out_last;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  int bp_mode = 0;
  int bpc = 0;
  int stall_max = 0;
  int hold_bad = 0;

  logic [15:0] rk [0:63];
  logic [31:0] rd [0:63];
  int nrows = 0;
  logic [15:0] ek [0:63];
  logic [31:0] ev [0:63];
  logic        el [0:63];
  int nexp = 0;
  logic [15:0] gk [0:63];
  logic [31:0] gv [0:63];
  logic        gl [0:63];
  int ngot = 0;

  always #5 clk = ~clk;

  grp_agg_top u0 (
    .clk(clk), .rst_n(rst_n), .op_sel(op_sel),
    .in_valid(in_valid), .in_ready(in_ready), .in_key(in_key), .in_data(in_data),
    .in_last(in_last), .in_hollow(in_hollow),
    .out_valid(out_valid), .out_ready(out_ready), .out_key(out_key),
    .out_value(out_value), .out_last(out_last)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    #2;
    bpc = bpc + 1;
    out_ready = (bp_mode == 0) ? 1'b1 : ((bpc % 3) != 1);
  end

  logic        pv_stall = 1'b0;
  logic [15:0] pk;
  logic [31:0] pvv;
  logic        pl;
  always @(negedge clk) begin
    if (rst_n) begin
      if (pv_stall && !(out_valid && out_key == pk && out_value == pvv && out_last == pl))
        hold_bad = hold_bad + 1;
      pv_stall = out_valid && !out_ready;
      pk = out_key; pvv = out_value; pl = out_last;
      if (out_valid && out_ready) begin
        if (ngot < 64) begin
          gk[ngot] = out_key; gv[ngot] = out_value; gl[ngot] = out_last;
        end
        ngot = ngot + 1;
      end
    end
  end

  task automatic summary_exit();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cycles > 150000) begin
      bad = bad + 1;
      $display("FAIL watchdog: actual=%0d cycles expected<150000", cycles);
      summary_exit();
    end
  end

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total = total + 1;
    if (!ok) begin
      bad = bad + 1;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic gen(input int n, input logic [31:0] seed, input logic big);
    logic [31:0] s;
    logic [15:0] k;
    s = seed;
    k = seed[15:0];
    nrows = n;
    for (int i = 0; i < n; i++) begin
      s = s * 32'd1103515245 + 32'd12345;
      if (i > 0 && (s[9:8] == 2'd0)) k = k + 16'd1 + 16'(s[3:2]);
      rk[i] = k;
      rd[i] = big ? (32'hFFFF0000 | {16'h0, s[31:16]}) : {20'h0, s[27:16]};
    end
  endtask

  task automatic build_exp(input logic [2:0] op);
    logic [31:0] mx, mn;
    logic [63:0] sm, ct;
    int g;
    nexp = 0;
    g = 0;
    while (g < nrows) begin
      mx = rd[g]; mn = rd[g]; sm = 64'(rd[g]); ct = 1;
      while (g + 1 < nrows && rk[g+1] == rk[g]) begin
        g = g + 1;
        if (rd[g] > mx) mx = rd[g];
        if (rd[g] < mn) mn = rd[g];
        sm = sm + 64'(rd[g]);
        ct = ct + 1;
      end
      ek[nexp] = rk[g];
      case (op)
        3'd0: ev[nexp] = mx;
        3'd1: ev[nexp] = mn;
        3'd2: ev[nexp] = ct[31:0];
        3'd4: ev[nexp] = 32'(sm / ct);
        default: ev[nexp] = sm[31:0];
      endcase
      el[nexp] = (g == nrows - 1);
      nexp = nexp + 1;
      g = g + 1;
    end
  endtask

  task automatic send_beat(input logic [15:0] k, input logic [31:0] d, input logic l, input logic h);
    int run;
    @(negedge clk);
    in_valid = 1'b1; in_key = k; in_data = d; in_last = l; in_hollow = h;
    #1;
    run = 0;
    while (!in_ready) begin
      run = run + 1;
      if (run > stall_max) stall_max = run;
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    in_valid = 1'b0; in_last = 1'b0; in_hollow = 1'b0;
  endtask

  // op: code, bp: stall output, hend: end by hollow beat, chg: alter op_sel mid-stream,
  // mid: insert a hollow beat without last
  task automatic run_stream(input logic [2:0] op, input int bp, input logic hend,
                            input logic chg, input logic mid, input string req);
    int w;
    build_exp(op);
    ngot = 0;
    hold_bad = 0;
    stall_max = 0;
    bp_mode = bp;
    op_sel = op;
    for (int i = 0; i < nrows; i++) begin
      send_beat(rk[i], rd[i], (!hend && i == nrows - 1), 1'b0);
      if (chg && i == 1) op_sel = (op == 3'd1) ? 3'd0 : 3'd1;
      if (mid && i == 2) send_beat(16'hFFFF, 32'hDEAD, 1'b0, 1'b1);
    end
    if (hend) send_beat(16'h0, 32'h0, 1'b1, 1'b1);
    w = 0;
    while (ngot < nexp && w < 20000) begin
      @(negedge clk);
      w = w + 1;
    end
    repeat (30) @(negedge clk);
    chk(ngot == nexp, {req, " row count"}, 64'(ngot), 64'(nexp));
    for (int i = 0; i < nexp && i < ngot; i++) begin
      chk(gk[i] == ek[i], {req, " key"}, 64'(gk[i]), 64'(ek[i]));
      chk(gv[i] == ev[i], {req, " value"}, 64'(gv[i]), 64'(ev[i]));
      chk(gl[i] == el[i], {req, " last"}, 64'(gl[i]), 64'(el[i]));
    end
    chk(hold_bad == 0, "R9 stalled row held", 64'(hold_bad), 64'd0);
    bp_mode = 0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid after reset", 64'(out_valid), 64'd0);
    chk(in_ready == 1'b1, "R1 in_ready after reset", 64'(in_ready), 64'd1);
  endtask

  task automatic t_sum();      gen(12, 32'h1234, 1'b0); run_stream(3'd3, 0, 1'b0, 1'b0, 1'b0, "R2 R3 total"); endtask
  task automatic t_max();      gen(14, 32'h0777, 1'b0); run_stream(3'd0, 1, 1'b0, 1'b0, 1'b0, "R3 R9 largest"); endtask
  task automatic t_min();      gen(14, 32'h5A5A, 1'b0); run_stream(3'd1, 1, 1'b0, 1'b0, 1'b0, "R3 smallest"); endtask
  task automatic t_count();    gen(20, 32'h9001, 1'b0); run_stream(3'd2, 0, 1'b0, 1'b0, 1'b0, "R3 count"); endtask
  task automatic t_unused();   gen(10, 32'h4242, 1'b0); run_stream(3'd6, 0, 1'b0, 1'b0, 1'b0, "R3 unused code"); endtask

  task automatic t_avg();
    gen(12, 32'hBEEF, 1'b1);
    run_stream(3'd4, 1, 1'b0, 1'b0, 1'b0, "R5 mean");
    chk(stall_max >= 60, "R5 input stall while dividing", 64'(stall_max), 64'd60);
  endtask

  task automatic t_wrap();
    nrows = 3;
    rk[0] = 16'd9; rd[0] = 32'hFFFFFFFF;
    rk[1] = 16'd9; rd[1] = 32'hFFFFFFFF;
    rk[2] = 16'd9; rd[2] = 32'h00000005;
    run_stream(3'd3, 0, 1'b0, 1'b0, 1'b0, "R4 total truncation");
    run_stream(3'd4, 0, 1'b0, 1'b0, 1'b0, "R4 R5 mean of wide total");
  endtask

  task automatic t_single_last();
    nrows = 4;
    rk[0] = 16'd1; rd[0] = 32'd10;
    rk[1] = 16'd1; rd[1] = 32'd20;
    rk[2] = 16'd4; rd[2] = 32'd7;
    rk[3] = 16'd8; rd[3] = 32'd3;
    run_stream(3'd3, 1, 1'b0, 1'b0, 1'b0, "R6 last row opens new group");
    run_stream(3'd4, 0, 1'b0, 1'b0, 1'b0, "R6 mean last row opens new group");
  endtask

  task automatic t_hollow_end();
    gen(9, 32'h3141, 1'b0);
    run_stream(3'd0, 0, 1'b1, 1'b0, 1'b1, "R6 hollow end marker");
    gen(9, 32'h2718, 1'b0);
    run_stream(3'd4, 1, 1'b1, 1'b0, 1'b0, "R6 mean hollow end");
  endtask

  task automatic t_empty();
    nrows = 0;
    run_stream(3'd3, 0, 1'b1, 1'b0, 1'b0, "R7 empty stream");
    gen(6, 32'h0F0F, 1'b0);
    run_stream(3'd3, 0, 1'b0, 1'b0, 1'b0, "R7 stream after empty");
  endtask

  task automatic t_opchg();
    gen(12, 32'h6666, 1'b0);
    run_stream(3'd0, 0, 1'b0, 1'b1, 1'b0, "R8 op change ignored");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_sum();
    t_max();
    t_min();
    t_count();
    t_unused();
    t_avg();
    t_wrap();
    t_single_last();
    t_hollow_end();
    t_empty();
    t_opchg();
    summary_exit();
  end
endmodule